// File: doc/BRIEF.md
# Vectored Interrupt Collector

This block gathers a parameterised set of level-sensitive interrupt lines (66 by default) and presents them to a processor as two request outputs. The normal request output carries prioritised interrupts. The fast request output carries sources that are routed to the fast path. Each source has a configuration word with four fields: a two-bit priority, an enable, a software request and a fast-path routing flag. The winning normal source is reported through a vector register. That register returns a programmable table base plus four times the source number, so a handler can fetch its entry point from the value directly.

Software announces that a handler has been entered in one of two ways. It can write the vector register with any value. It can also read the vector register while the read-side-effect mode is on. Either action marks the priority level of the current winner as in service. While a level is in service, requests at that level or lower are held back. A write to the level acknowledge register ends service of the levels whose bits are set. The register interface is a single-cycle select/write bus. Every register can also be written through a set alias at +4 and a clear alias at +8.

Top module: `intc_vectored`

## Requirements
- R1: After reset, every source word, the control register, the vector base and the in-service mask read as zero, and `irq_o` and `fiq_o` are low.
- R2: A source word lives at 0x120 + 0x10 × n. Its fields are priority in bits [1:0], enable in bit 2, software request in bit 3 and fast routing in bit 4. All higher bits read as zero.
- R3: A write to a register's base offset replaces its contents. A write at +4 ORs in the written ones, and a write at +8 clears them.
- R4: A source is pending only when its enable bit is 1 and either its input line or its software request bit is 1. A disabled source takes no part in selection.
- R5: Among pending normal sources, the winner is the one with the highest priority value. On a tie, the lowest source number wins.
- R6: Reading offset 0x00 returns the vector base (offset 0x40) plus 4 × the winner's number. With no pending normal source it returns the base alone.
- R7: `irq_o` rises one cycle after a winner exists and control bit 16 is 1. It stays low while bit 16 is 0.
- R8: A pending source with fast routing drives `fiq_o` one cycle later, whatever the state of control bit 16. Such a source is never the vector winner.
- R9: Writing offset 0x00 while a winner exists sets bit p of the in-service mask, where p is the winner's priority. Offset 0x10 reads back that mask.
- R10: While any level is in service, `irq_o` is asserted only if the winner's priority is strictly above the highest in-service level.
- R11: Writing a value to offset 0x10 clears every in-service bit set in that value. For example, 0x1 ends level 0 and 0x4 ends level 2.
- R12: Control bit 18 enables read-side-effect mode, in which a read of offset 0x00 acts like a vector write for R9. With bit 18 at 0, reads change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_SRC | Level-sensitive interrupt inputs, one per source |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] choose plain/set/clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The hardest situation to reach is a level held in service while a strictly higher-priority request arrives, then leaves again before the acknowledge. Only that sequence shows the hold-off comparison letting one request through and holding back another. The bench reaches it in steps. It first uses software request bits to create a priority-2 winner and enters it through a vector write. It then raises a priority-3 input line and drops it again, and only after that writes the acknowledge. The same prepared state is then reused to show that read-side-effect mode makes a vector read equivalent to that write.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } bus_op_e;

  localparam int OFS_VECTOR = 'h000;
  localparam int OFS_LVLACK = 'h010;
  localparam int OFS_CTRL   = 'h020;
  localparam int OFS_VBASE  = 'h040;
  localparam int OFS_SRC0   = 'h120;

  localparam int CTRL_FINAL_BIT = 16;
  localparam int CTRL_RSE_BIT   = 18;

  // Apply a plain, set or clear access to a 32-bit register image.
  function automatic logic [31:0] merge_write(logic [31:0] old, logic [31:0] wd, bus_op_e op);
    case (op)
      OP_WRITE: return wd;
      OP_SET:   return old | wd;
      OP_CLR:   return old & ~wd;
      default:  return old;
    endcase
  endfunction

  // Single-bit form of merge_write for scattered control bits.
  function automatic logic merge_bit(logic old, logic wd, bus_op_e op);
    case (op)
      OP_WRITE: return wd;
      OP_SET:   return old | wd;
      OP_CLR:   return old & ~wd;
      default:  return old;
    endcase
  endfunction

  // Table entry address of a source: base + 4 * index, or the base alone.
  function automatic logic [31:0] vector_of(logic [31:0] base, logic valid, logic [31:0] idx);
    return valid ? base + (idx << 2) : base;
  endfunction

  // Candidate beats current best when higher priority, or equal (scan runs high index to low).
  function automatic logic outranks(logic have_best, logic [7:0] cand, logic [7:0] best);
    return !have_best || (cand >= best);
  endfunction

endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 66,
  parameter int PRIO_W  = 2
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [$clog2(NUM_SRC)-1:0] idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  import intc_pkg::*;
  localparam int IDX_W = $clog2(NUM_SRC);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && outranks(valid_o, 8'(prio_i[i*PRIO_W +: PRIO_W]), 8'(prio_o))) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intc_svc_levels.sv
module intc_svc_levels #(
  parameter int PRIO_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enter_i,
  input  logic [PRIO_W-1:0]      enter_lvl_i,
  input  logic                   ack_i,
  input  logic [(1<<PRIO_W)-1:0] ack_mask_i,
  output logic [(1<<PRIO_W)-1:0] mask_o,
  output logic                   any_o,
  output logic [PRIO_W-1:0]      top_o
);
  localparam int LEVELS = 1 << PRIO_W;

  logic [LEVELS-1:0] set_vec, clr_vec;
  assign set_vec = enter_i ? (LEVELS'(1) << enter_lvl_i) : '0;
  assign clr_vec = ack_i ? ack_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_o <= '0;
    else        mask_o <= (mask_o & ~clr_vec) | set_vec;
  end

  assign any_o = |mask_o;

  always_comb begin
    top_o = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (mask_o[l]) top_o = PRIO_W'(l);
    end
  end
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored #(
  parameter int NUM_SRC = 66,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  import intc_pkg::*;

  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int LEVELS  = 1 << PRIO_W;
  localparam int EN_BIT  = PRIO_W;
  localparam int SW_BIT  = PRIO_W + 1;
  localparam int FIQ_BIT = PRIO_W + 2;
  localparam int CFG_W   = PRIO_W + 3;

  // ---- bus decode ----
  bus_op_e           op;
  logic [ADDR_W-1:0] addr_base, src_off, src_slot;
  logic              aligned, wr_fire, rd_fire;
  logic              hit_vec, hit_ack, hit_ctrl, hit_vbase, hit_src;
  logic [IDX_W-1:0]  src_idx;

  assign op        = bus_op_e'(bus_addr[3:2]);
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign addr_base = {bus_addr[ADDR_W-1:4], 4'h0};
  assign wr_fire   = bus_sel & bus_wr & aligned & (op != OP_NONE);
  assign rd_fire   = bus_sel & ~bus_wr & aligned;
  assign hit_vec   = (addr_base == ADDR_W'(OFS_VECTOR));
  assign hit_ack   = (addr_base == ADDR_W'(OFS_LVLACK));
  assign hit_ctrl  = (addr_base == ADDR_W'(OFS_CTRL));
  assign hit_vbase = (addr_base == ADDR_W'(OFS_VBASE));
  assign src_off   = addr_base - ADDR_W'(OFS_SRC0);
  assign src_slot  = src_off >> 4;
  assign hit_src   = (addr_base >= ADDR_W'(OFS_SRC0)) && (src_slot < ADDR_W'(NUM_SRC));
  assign src_idx   = IDX_W'(src_slot);

  // ---- registers ----
  logic [CFG_W-1:0] cfg_q [NUM_SRC];
  logic [31:0]      vbase_q;
  logic             final_en, rse_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '0;
    end else if (wr_fire && hit_src) begin
      cfg_q[src_idx] <= CFG_W'(merge_write(32'(cfg_q[src_idx]), bus_wdata, op));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbase_q  <= '0;
      final_en <= 1'b0;
      rse_en   <= 1'b0;
    end else begin
      if (wr_fire && hit_vbase) vbase_q <= merge_write(vbase_q, bus_wdata, op);
      if (wr_fire && hit_ctrl) begin
        final_en <= merge_bit(final_en, bus_wdata[CTRL_FINAL_BIT], op);
        rse_en   <= merge_bit(rse_en, bus_wdata[CTRL_RSE_BIT], op);
      end
    end
  end

  // ---- pending computation ----
  logic [NUM_SRC-1:0]        pend_irq, pend_fiq;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic live;
    assign live        = cfg_q[g][EN_BIT] & (irq_lines[g] | cfg_q[g][SW_BIT]);
    assign pend_irq[g] = live & ~cfg_q[g][FIQ_BIT];
    assign pend_fiq[g] = live &  cfg_q[g][FIQ_BIT];
    assign prio_flat[g*PRIO_W +: PRIO_W] = cfg_q[g][PRIO_W-1:0];
  end

  // ---- selection ----
  logic              sel_valid;
  logic [IDX_W-1:0]  sel_idx;
  logic [PRIO_W-1:0] sel_prio;

  intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_i  (pend_irq),
    .prio_i  (prio_flat),
    .valid_o (sel_valid),
    .idx_o   (sel_idx),
    .prio_o  (sel_prio)
  );

  // ---- in-service tracking ----
  logic              enter_fire, ack_fire, svc_any;
  logic [LEVELS-1:0] svc_mask, ack_mask;
  logic [PRIO_W-1:0] svc_top;

  assign enter_fire = ((wr_fire & hit_vec) | (rd_fire & hit_vec & rse_en)) & sel_valid;
  assign ack_fire   = wr_fire & hit_ack;
  assign ack_mask   = bus_wdata[LEVELS-1:0];

  intc_svc_levels #(.PRIO_W(PRIO_W)) u_svc (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_i     (enter_fire),
    .enter_lvl_i (sel_prio),
    .ack_i       (ack_fire),
    .ack_mask_i  (ack_mask),
    .mask_o      (svc_mask),
    .any_o       (svc_any),
    .top_o       (svc_top)
  );

  // ---- request outputs ----
  logic allow, irq_next, fiq_next;
  assign allow    = ~svc_any | (sel_prio > svc_top);
  assign irq_next = final_en & sel_valid & allow;
  assign fiq_next = |pend_fiq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_next;
      fiq_o <= fiq_next;
    end
  end

  // ---- read mux ----
  logic [31:0] ctrl_img;
  always_comb begin
    ctrl_img = '0;
    ctrl_img[CTRL_FINAL_BIT] = final_en;
    ctrl_img[CTRL_RSE_BIT]   = rse_en;
    bus_rdata = '0;
    if (aligned) begin
      if (hit_vec)        bus_rdata = vector_of(vbase_q, sel_valid, 32'(sel_idx));
      else if (hit_ack)   bus_rdata = 32'(svc_mask);
      else if (hit_ctrl)  bus_rdata = ctrl_img;
      else if (hit_vbase) bus_rdata = vbase_q;
      else if (hit_src)   bus_rdata = 32'(cfg_q[src_idx]);
    end
  end
endmodule

// File: rtl/intc_vectored_chk.sv
module intc_vectored_chk #(
  parameter int NUM_SRC = 66,
  parameter int PRIO_W  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       irq_o,
  input logic                       fiq_o,
  input logic                       final_en,
  input logic                       sel_valid,
  input logic [$clog2(NUM_SRC)-1:0] sel_idx,
  input logic [PRIO_W-1:0]          sel_prio,
  input logic [NUM_SRC-1:0]         pend_irq,
  input logic [NUM_SRC-1:0]         pend_fiq,
  input logic [(1<<PRIO_W)-1:0]     svc_mask,
  input logic                       svc_any,
  input logic [PRIO_W-1:0]          svc_top,
  input logic                       enter_fire,
  input logic                       ack_fire,
  input logic [(1<<PRIO_W)-1:0]     ack_mask
);
  // R7: no request without the final enable in the preceding cycle
  p_irq_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(final_en));

  // R8: the vector winner is always a pending normal (non-fast) source
  p_sel_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> pend_irq[sel_idx]);

  // R8: fast request only follows a pending fast source
  p_fiq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(|pend_fiq));

  // R9: handler entry marks the winner's level
  p_enter_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enter_fire |=> svc_mask[$past(sel_prio)]);

  // R10: hold-off against the highest in-service level
  p_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(!svc_any || (sel_prio > svc_top)));

  // R11: acknowledged levels are cleared
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !enter_fire) |=> ((svc_mask & $past(ack_mask)) == '0));
endmodule

bind intc_vectored intc_vectored_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .final_en   (final_en),
  .sel_valid  (sel_valid),
  .sel_idx    (sel_idx),
  .sel_prio   (sel_prio),
  .pend_irq   (pend_irq),
  .pend_fiq   (pend_fiq),
  .svc_mask   (svc_mask),
  .svc_any    (svc_any),
  .svc_top    (svc_top),
  .enter_fire (enter_fire),
  .ack_fire   (ack_fire),
  .ack_mask   (ack_mask)
);

// File: tb/test_intc_vectored.sv
module test_intc_vectored;
  localparam int NUM_SRC = 66;
  localparam int N_VEC   = 22;
  localparam logic [31:0] BASE = 32'h8000_1000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_SRC-1:0] irq_lines = '0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  intc_vectored i_intc_vectored (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // {is_write, address, data (write value or expected read), requirement}
  localparam logic [52:0] VEC [N_VEC] = '{
    {1'b1, 12'h040, 32'h8000_1000, 8'd6},  // R6 program vector base
    {1'b0, 12'h040, 32'h8000_1000, 8'd3},  // R3 plain write readback
    {1'b1, 12'h024, 32'h0001_0000, 8'd3},  // R3 set final enable
    {1'b0, 12'h020, 32'h0001_0000, 8'd3},  // R3
    {1'b1, 12'h170, 32'hFFFF_FFFF, 8'd2},  // R2 all ones into source 5
    {1'b0, 12'h170, 32'h0000_001F, 8'd2},  // R2 only five field bits exist
    {1'b1, 12'h178, 32'h0000_0018, 8'd3},  // R3 clear sw+fast
    {1'b0, 12'h170, 32'h0000_0007, 8'd3},  // R3
    {1'b0, 12'h000, 32'h8000_1000, 8'd6},  // R6 nothing pending -> base
    {1'b1, 12'h154, 32'h0000_000D, 8'd4},  // R4 source 3 sw, prio 1
    {1'b0, 12'h000, 32'h8000_100C, 8'd6},  // R6 base + 4*3
    {1'b1, 12'h534, 32'h0000_000E, 8'd5},  // R5 source 65 sw, prio 2
    {1'b0, 12'h000, 32'h8000_1104, 8'd5},  // R5 higher priority wins
    {1'b1, 12'h1C4, 32'h0000_000E, 8'd5},  // R5 source 10 sw, prio 2
    {1'b0, 12'h000, 32'h8000_1028, 8'd5},  // R5 tie -> lower index
    {1'b1, 12'h000, 32'h0000_0000, 8'd9},  // R9 handler entry
    {1'b0, 12'h010, 32'h0000_0004, 8'd9},  // R9 level 2 in service
    {1'b1, 12'h010, 32'h0000_0004, 8'd11}, // R11 acknowledge level 2
    {1'b0, 12'h010, 32'h0000_0000, 8'd11}, // R11
    {1'b1, 12'h1C8, 32'h0000_0008, 8'd4},  // R4 drop sw on source 10
    {1'b0, 12'h000, 32'h8000_1104, 8'd4},  // R4 source 10 no longer pending
    {1'b0, 12'h1C0, 32'h0000_0006, 8'd3}   // R3 clear left other bits
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(1, 32'(irq_o), 0);
    check(1, 32'(fiq_o), 0);
    bus_read(12'h020, v); check(1, v, 0);
    bus_read(12'h530, v); check(1, v, 0);
    bus_read(12'h010, v); check(1, v, 0);
    bus_read(12'h000, v); check(1, v, 0);

    for (int k = 0; k < N_VEC; k++) begin
      if (VEC[k][52]) bus_write(VEC[k][51:40], VEC[k][39:8]);
      else begin
        bus_read(VEC[k][51:40], v);
        check(int'(VEC[k][7:0]), v, VEC[k][39:8]);
      end
    end

    // R7 final enable gates the request
    settle(); check(7, 32'(irq_o), 1);
    bus_write(12'h028, 32'h0001_0000); settle(); check(7, 32'(irq_o), 0);
    bus_write(12'h024, 32'h0001_0000); settle(); check(7, 32'(irq_o), 1);

    // R4 input line on enabled source 5 (prio 3), then disabled
    irq_lines[5] = 1'b1;
    bus_read(12'h000, v); check(4, v, BASE + 32'd20);
    bus_write(12'h178, 32'h0000_0004);
    bus_read(12'h000, v); check(4, v, BASE + 32'd260);
    irq_lines[5] = 1'b0;

    // R10 hold-off while level 2 is in service
    bus_write(12'h000, 32'h0);
    settle(); check(10, 32'(irq_o), 0);
    bus_read(12'h010, v); check(9, v, 32'h4);
    irq_lines[5] = 1'b1;
    bus_write(12'h174, 32'h0000_0004);
    settle(); check(10, 32'(irq_o), 1);
    irq_lines[5] = 1'b0;
    settle(); check(10, 32'(irq_o), 0);
    bus_write(12'h010, 32'h0000_0004);
    settle(); check(11, 32'(irq_o), 1);

    // R8 fast routing on source 0 (prio 3, enabled, fast)
    bus_write(12'h120, 32'h0000_0017);
    irq_lines[0] = 1'b1;
    settle(); check(8, 32'(fiq_o), 1);
    bus_read(12'h000, v); check(8, v, BASE + 32'd260);
    bus_write(12'h028, 32'h0001_0000);
    settle(); check(8, 32'(fiq_o), 1);
    check(7, 32'(irq_o), 0);
    bus_write(12'h024, 32'h0001_0000);
    irq_lines[0] = 1'b0;
    settle(); check(8, 32'(fiq_o), 0);

    // R12 read-side-effect mode
    bus_read(12'h000, v); check(12, v, BASE + 32'd260);
    bus_read(12'h010, v); check(12, v, 32'h0);
    bus_write(12'h024, 32'h0004_0000);
    bus_read(12'h020, v); check(12, v, 32'h0005_0000);
    bus_read(12'h000, v); check(12, v, BASE + 32'd260);
    bus_read(12'h010, v); check(12, v, 32'h4);
    bus_write(12'h010, 32'h0000_0004);
    bus_read(12'h010, v); check(11, v, 32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule